// File: doc/BRIEF.md
# Prescaled Programmable Clock Divider

This block derives a slow main clock from a reference. The reference first passes a prescaler that divides it by 1, 2 or 4, which gives the master clock. A programmable divider then divides the master clock by a 9-bit code plus two. An output-enable that may arrive at any time gates the result, and the gating is built so that a high pulse on the main output is never cut short. A bypass setting sends the master clock straight to the output. The chosen reference source decides whether the prescaler takes part at all.

The design is fully synchronous. `clk_i` runs at twice the reference rate, so one reference period spans two `clk_i` cycles. Both clocks the block produces are registered waveforms sampled in the `clk_i` domain, and every change on them falls on a `clk_i` rising edge. Configuration inputs are assumed static whenever the enable is active.

Top module: `presc_clk_div`

## Requirements
- R1: With the internal reference selected and bypass off, `mclk_o` has a period of 2P `clk_i` cycles and is high for P of them. P is 4 when `msel_i`=0 and `m_i`=0, 2 when `msel_i`=0 and `m_i`=1, and 1 when `msel_i`=1.
- R2: When `ext_sel_i`=1, P is 1 whatever `msel_i` and `m_i` are. The divided output then uses the unscaled reference.
- R3: When `div1_i`=0, `out_o` repeats every N periods of `mclk_o`, where N = `ndiv_i`+2. It is high for floor(N/2) of those periods and low for the rest.
- R4: When `div1_i`=1, `ndiv_i` is ignored and `out_o` follows `mclk_o` while enabled. If the internal reference is selected, P is forced to 1.
- R5: Once the deassertion of `oe_i` has taken effect, `out_o` stays low and `mclk_o` keeps toggling. The divider count returns to zero at that point, so a later enable always starts from the same phase.
- R6: Whatever the timing of the fall of `oe_i`, every high pulse on `out_o` has its full width. A pulse that is high when the disable arrives runs to its normal end before the output is held low.
- R7: `oe_i` is sampled on the rising edges of `mclk_o` through two synchronizing stages. Counting the first `mclk_o` rise after `oe_i` goes high as rise 1, `out_o` first goes high together with rise 3 when `div1_i`=0, and together with rise 2 when `div1_i`=1.
- R8: While `rst_ni` is low, both `out_o` and `mclk_o` are low.
- R9: The largest code, 511, gives N=513. `out_o` is then high for 256 master periods out of 513.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sampling clock at twice the reference rate |
| rst_ni | input | 1 | Asynchronous reset, active low |
| oe_i | input | 1 | Asynchronous output enable, active high |
| div1_i | input | 1 | Bypass of the N divider |
| msel_i | input | 1 | 1 bypasses the prescaler |
| m_i | input | 1 | Prescaler ratio: 0 gives /4, 1 gives /2 |
| ndiv_i | input | 9 | Divider code; divisor is code+2 |
| ext_sel_i | input | 1 | 1 selects the external reference |
| out_o | output | 1 | Divided, gated main clock |
| mclk_o | output | 1 | Prescaled master clock |

## Verification
Two events can land on the same master edge: the synchronized disable reaching the gating logic, and the divider reaching the end of the high phase of `out_o`. The bench provokes this coincidence by dropping `oe_i` at every few cycle offsets across a whole output period. A scoreboard then compares the high width of every pulse with floor(N/2)·2P cycles, so any pulse that is shortened or stretched where the two events meet is reported. After each disable the bench also confirms that the output stays low while the master clock keeps running.

// File: rtl/pdiv_pkg.sv
package pdiv_pkg;
  localparam int RATIO_W = 3;

  // prescale ratio: external ref, bypass or msel force /1
  function automatic logic [RATIO_W-1:0] prescale_ratio(
    input logic ext_sel,
    input logic div1,
    input logic msel,
    input logic m
  );
    if (ext_sel || div1 || msel) return RATIO_W'(1);
    else if (m)                  return RATIO_W'(2);
    else                         return RATIO_W'(4);
  endfunction
endpackage

// File: rtl/pdiv_prescaler.sv
module pdiv_prescaler #(
  parameter int RW = 3
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [RW-1:0] ratio_i,
  output logic          mclk_o,
  output logic          tick_o
);
  localparam int CW = RW + 1;

  logic [CW-1:0] pc_q, pc_nxt, last;
  logic          mclk_q;

  assign last   = {ratio_i, 1'b0} - CW'(1);
  assign tick_o = (pc_q >= last);
  assign pc_nxt = tick_o ? '0 : pc_q + CW'(1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pc_q   <= '1;
      mclk_q <= 1'b0;
    end else begin
      pc_q   <= pc_nxt;
      mclk_q <= (pc_nxt < {1'b0, ratio_i});
    end
  end

  assign mclk_o = mclk_q;
endmodule

// File: rtl/pdiv_oe_sync.sv
module pdiv_oe_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic async_i,
  output logic sync_o
);
  logic [STAGES-1:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   sh_q <= '0;
    else if (en_i) sh_q <= {sh_q[STAGES-2:0], async_i};
  end

  assign sync_o = sh_q[STAGES-1];
endmodule

// File: rtl/pdiv_ndivider.sv
module pdiv_ndivider #(
  parameter int CODE_W = 9
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            tick_i,
  input  logic            run_i,
  input  logic [CODE_W-1:0] code_i,
  output logic            out_o,
  output logic [CODE_W:0] cnt_o
);
  localparam int NW = CODE_W + 1;

  logic [NW-1:0] n_val, half, cnt_q;
  logic          out_q, en;

  assign n_val = {1'b0, code_i} + NW'(2);
  assign half  = n_val >> 1;
  // keep counting while a high phase is still unfinished
  assign en    = run_i || (out_q && (cnt_q < half));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      out_q <= 1'b0;
    end else if (tick_i) begin
      if (en) begin
        out_q <= (cnt_q < half);
        cnt_q <= (cnt_q == n_val - NW'(1)) ? '0 : cnt_q + NW'(1);
      end else begin
        out_q <= 1'b0;
        cnt_q <= '0;
      end
    end
  end

  assign out_o = out_q;
  assign cnt_o = cnt_q;
endmodule

// File: rtl/presc_clk_div.sv
module presc_clk_div #(
  parameter int CODE_W    = 9,
  parameter int SYNC_STGS = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              oe_i,
  input  logic              div1_i,
  input  logic              msel_i,
  input  logic              m_i,
  input  logic [CODE_W-1:0] ndiv_i,
  input  logic              ext_sel_i,
  output logic              out_o,
  output logic              mclk_o
);
  import pdiv_pkg::*;

  logic [RATIO_W-1:0] ratio;
  logic               mclk, tick, oe_s, nout;
  logic [CODE_W:0]    cnt;

  assign ratio = prescale_ratio(ext_sel_i, div1_i, msel_i, m_i);

  pdiv_prescaler #(.RW(RATIO_W)) u_pre (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .ratio_i (ratio),
    .mclk_o  (mclk),
    .tick_o  (tick)
  );

  pdiv_oe_sync #(.STAGES(SYNC_STGS)) u_sync (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .en_i    (tick),
    .async_i (oe_i),
    .sync_o  (oe_s)
  );

  pdiv_ndivider #(.CODE_W(CODE_W)) u_ndiv (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_i (tick),
    .run_i  (oe_s && !div1_i),
    .code_i (ndiv_i),
    .out_o  (nout),
    .cnt_o  (cnt)
  );

  // oe_s only changes on a master rise, while mclk was low
  assign out_o  = div1_i ? (mclk && oe_s) : nout;
  assign mclk_o = mclk;
endmodule

// File: rtl/pdiv_checker.sv
module pdiv_checker #(
  parameter int CODE_W = 9
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              div1_i,
  input logic [CODE_W-1:0] ndiv_i,
  input logic              tick,
  input logic              oe_s,
  input logic              mclk_o,
  input logic              out_o,
  input logic [CODE_W:0]   cnt
);
  AST_MCLK_RISE_ON_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mclk_o) |-> $past(tick)); // R1

  AST_OUT_FALL_ON_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!div1_i && $fell(out_o)) |-> $past(tick)); // R6

  AST_OUT_RISE_NEEDS_OE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!div1_i && $rose(out_o)) |-> $past(oe_s)); // R7

  AST_HOLD_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!div1_i && !oe_s && !out_o) |=> !out_o); // R5

  AST_CNT_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt < ({1'b0, ndiv_i} + (CODE_W+1)'(2))); // R3
endmodule

bind presc_clk_div pdiv_checker #(.CODE_W(CODE_W)) u_pdiv_checker (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .div1_i (div1_i),
  .ndiv_i (ndiv_i),
  .tick   (tick),
  .oe_s   (oe_s),
  .mclk_o (mclk_o),
  .out_o  (out_o),
  .cnt    (cnt)
);

// File: tb/presc_clk_div_bench.sv
module presc_clk_div_bench;
  localparam int CLK_PERIOD = 10;
  localparam int CW = 9;

  typedef struct {int hi; int per;} exp_t;

  logic clk = 1'b0, rst_n = 1'b0, oe = 1'b0;
  logic div1 = 1'b0, msel = 1'b0, m = 1'b0, ext = 1'b0;
  logic [CW-1:0] code = '0;
  logic out, mclk;

  exp_t  q[$];
  exp_t  e_pop;
  int    errors = 0, checks = 0, falls = 0;
  int    percnt = 0, hicnt = 0, pend_per = 0;
  bit    mon_en = 0, pend = 0, prev_o = 0, done = 0;
  string cur_req = "R3";

  always #(CLK_PERIOD/2) clk = ~clk;

  presc_clk_div u_presc_clk_div (
    .clk_i(clk), .rst_ni(rst_n), .oe_i(oe), .div1_i(div1), .msel_i(msel),
    .m_i(m), .ndiv_i(code), .ext_sel_i(ext), .out_o(out), .mclk_o(mclk)
  );

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // monitor: measures every output pulse, pops expectation
  always @(negedge clk) if (mon_en) begin
    if (out && !prev_o) begin
      if (pend) begin chk({cur_req, " period"}, percnt, pend_per); pend = 0; end
      percnt = 1; hicnt = 1;
    end else begin
      percnt++;
      if (out) hicnt++;
    end
    if (!out && prev_o) begin
      falls++;
      if (q.size() == 0) chk({cur_req, " unexpected pulse"}, 1, 0);
      else begin
        e_pop = q.pop_front();
        chk({cur_req, " high width"}, hicnt, e_pop.hi);
        pend = 1; pend_per = e_pop.per;
      end
    end
    prev_o = out;
  end

  task automatic flush();
    @(negedge clk); #1;
    pend = 0;
    q.delete();
  endtask

  task automatic cfg(bit e, bit d1, bit ms, bit mm, int c);
    @(negedge clk); #1;
    ext = e; div1 = d1; msel = ms; m = mm; code = CW'(c);
    repeat (20) @(negedge clk);
  endtask

  task automatic check_mclk(string req, int p);
    int hi = 0, per = 0;
    bit pm;
    @(negedge clk); pm = mclk;
    repeat (100) begin
      @(negedge clk);
      if (mclk && !pm) break;
      pm = mclk;
    end
    hi = 1; per = 1; pm = 1;
    repeat (100) begin
      @(negedge clk);
      if (mclk && !pm) break;
      per++;
      if (mclk) hi++;
      pm = mclk;
    end
    chk({req, " mclk high"}, hi, p);
    chk({req, " mclk period"}, per, 2*p);
  endtask

  // driver: queue expectations, enable, let pulses run, disable at offset
  task automatic run(string req, int hi, int per, int lat, int npulse, int off);
    int  rises = 0, f0, hits = 0, mr = 0;
    bit  pm;
    exp_t it;
    cur_req = req;
    it.hi = hi; it.per = per;
    repeat (64) q.push_back(it);
    @(negedge clk); #1;
    oe = 1'b1;
    pm = mclk;
    repeat (4000) begin
      @(negedge clk);
      if (mclk && !pm) rises++;
      pm = mclk;
      if (out) break;
    end
    chk("R7 enable latency in master rises", rises, lat);
    f0 = falls;
    while (falls < f0 + npulse) @(negedge clk);
    repeat (off) @(negedge clk);
    #1 oe = 1'b0;
    repeat (2*per + 40) @(negedge clk);
    pm = mclk;
    repeat (per + 8) begin
      @(negedge clk);
      if (out) hits++;
      if (mclk && !pm) mr++;
      pm = mclk;
    end
    chk("R5 output held low after disable", hits, 0);
    chk("R5 master clock keeps running", int'(mr > 0), 1);
    flush();
  endtask

  initial begin
    repeat (5) @(negedge clk);
    chk("R8 out during reset", int'(out), 0);
    chk("R8 mclk during reset", int'(mclk), 0);
    #1 rst_n = 1'b1;
    mon_en = 1;

    cfg(0, 0, 0, 0, 3);
    check_mclk("R1 divide by 4", 4);
    run("R3", 16, 40, 3, 3, 0);
    for (int off = 1; off < 40; off += 3) run("R6", 16, 40, 3, 1, off);

    cfg(0, 0, 0, 1, 0);
    check_mclk("R1 divide by 2", 2);
    run("R3", 4, 8, 3, 3, 1);
    for (int off = 0; off < 8; off++) run("R6", 4, 8, 3, 1, off);

    cfg(0, 0, 1, 0, 7);
    check_mclk("R1 prescaler bypass", 1);
    run("R3", 8, 18, 3, 3, 0);

    cfg(1, 0, 0, 0, 1);
    check_mclk("R2 external forces ratio 1", 1);
    run("R2", 2, 6, 3, 3, 2);

    cfg(0, 1, 0, 0, 100);
    check_mclk("R4 internal bypass forces ratio 1", 1);
    run("R4", 1, 2, 2, 4, 0);
    run("R4", 1, 2, 2, 4, 1);

    cfg(1, 1, 0, 1, 5);
    run("R4", 1, 2, 2, 4, 1);

    cfg(0, 0, 1, 0, 511);
    run("R9", 512, 1026, 3, 2, 100);

    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule